// File: doc/BRIEF.md
# Dual-Channel DAC Register Bank with Rolling Readback

This block keeps the code and span registers for a two-channel digital-to-analogue converter. Every channel has a staging pair (input code, input span) and a live pair (active code, active span). The live pair drives the converter. A serial-port front end decodes each frame into a one-cycle request. Depending on the operation, the request writes a staging register, copies staging into live for one channel or for all channels, or asks for a register to be read. An active-low load pin gives a second way to copy all channels at once. It is honoured only while chip select is high.

Every accepted frame also loads a 24-bit readback word. A read frame returns the register it names in that same frame. Any other frame returns the register that the previous write or update acted on, so each command checks the one before it. In manual span mode, the live span comes from three external pins, and span readback reports those pin levels.

The load pin goes through a two-flop synchroniser into a two-state machine. State `LD_HIGH` waits for the synchronised pin to go low. From `LD_HIGH` there are two transitions to `LD_LOW`:
- *fire*, taken when chip select is high, which raises the update-all strobe for one cycle.
- *lockout*, taken when chip select is low, which raises no strobe.

State `LD_LOW` waits for the pin to return high, and the *release* transition takes it back to `LD_HIGH`.

Top module: `dacbank_regs`

## Requirements
- R1: After reset, every code and span register is zero, the readback word is zero, and the rolling pointer names the channel 0 input code register.
- R2: A write frame (op 0) changes only the staging register of the addressed channel, and no active output moves. Bit 0 of the register field selects the target: 0 is input code and 1 is input span. The code is taken from data bits 23:6 and the span from data bits 11:8. All other data bits are ignored.
- R3: An update frame (op 1) copies input code and input span into the active pair of the addressed channel only. A write-and-update frame (op 2) performs the write first, so the newly written value reaches the active pair in that same frame.
- R4: An update-all frame (op 3) copies the staging pair into the active pair for every channel.
- R5: A read frame (op 4) loads the named register into the readback word in the same frame. Register codes are 0 input code, 1 input span, 2 active code and 3 active span. A code appears in bits 23:6 and a span in bits 11:8, and every other bit is zero.
- R6: A frame with op 0 to 3 loads the readback word with the register that the rolling pointer names, as it stood before the frame. The frame then moves the pointer as follows: a write points it at the written staging register, an update or write-and-update at that channel's active code, and an update-all at channel 0 active code. Read frames leave the pointer unchanged.
- R7: When the load pin falls while chip select is high, one update-all takes place. It appears on the active outputs at the third rising clock edge after the fall. Holding the pin low produces no further copy.
- R8: A load-pin fall seen while chip select is low has no effect. The pin stays locked out until it returns high, even if chip select rises first.
- R9: With manual span mode set, each active span output equals {0, span pins}, and both span readbacks report {0, span pins}. Stored span registers are still written, and they reappear when software span mode returns.
- R10: Op codes 5 to 7 change no register, the readback word or the pointer.
- R11: When a load event and a write frame fall in the same cycle, the write lands first and the copy then carries the new value. The readback word still comes from the state before the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle strobe for a decoded frame |
| req_op_i | input | 3 | Operation code (0 to 4 valid) |
| req_ch_i | input | CH_W | Addressed channel |
| req_reg_i | input | 2 | Register selector |
| req_data_i | input | RB_W | 24-bit data field of the frame |
| cs_n_i | input | 1 | Chip-select level, active low |
| ld_n_i | input | 1 | Asynchronous active-low load-all pin |
| mspan_i | input | 1 | 1 selects manual span from pins |
| span_pins_i | input | SPAN_W-1 | External span pin levels |
| act_code_o | output | NUM_CH*CODE_W | Active codes, channel 0 in the low slice |
| act_span_o | output | NUM_CH*SPAN_W | Effective active spans, channel 0 in the low slice |
| rb_word_o | output | RB_W | Readback word for the current frame |

## Verification
A frame request and a load-pin event can reach the register bank in the same clock edge. The bench causes this by dropping the load pin at a falling edge and raising the frame strobe two falling edges later, so that both are sampled on the third rising edge. The result is judged against the bench model: the written staging value must show up on the active outputs, the other channel must also be copied, and the readback word must reflect the state from before the frame.

// File: rtl/dacbank_pkg.sv
`timescale 1ns/1ps
package dacbank_pkg;

    typedef enum logic [2:0] {
        OP_WRITE      = 3'd0,
        OP_UPDATE     = 3'd1,
        OP_WRITE_UPD  = 3'd2,
        OP_UPDATE_ALL = 3'd3,
        OP_READ       = 3'd4
    } op_e;

    localparam logic [2:0] OP_LAST = 3'd4;

    typedef enum logic [1:0] {
        RG_IN_CODE  = 2'd0,
        RG_IN_SPAN  = 2'd1,
        RG_ACT_CODE = 2'd2,
        RG_ACT_SPAN = 2'd3
    } regsel_e;

    typedef enum logic {
        LD_HIGH = 1'b0,
        LD_LOW  = 1'b1
    } ld_state_e;

endpackage

// File: rtl/dacbank_ldsync.sv
`timescale 1ns/1ps
module dacbank_ldsync
    import dacbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_n_i,
    input  logic cs_n_i,
    output logic fire_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_lvl;
    ld_state_e              state_q;
    ld_state_e              state_d;

    // synchroniser chain, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ld_n_i};
        end
    end

    assign pin_lvl = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LD_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: fire / lockout (HIGH->LOW), release (LOW->HIGH)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_HIGH: if (!pin_lvl) state_d = LD_LOW;
            LD_LOW:  if (pin_lvl)  state_d = LD_HIGH;
            default: state_d = LD_HIGH;
        endcase
    end

    // outputs
    always_comb begin
        fire_o = 1'b0;
        unique case (state_q)
            LD_HIGH: fire_o = !pin_lvl && cs_n_i;
            LD_LOW:  fire_o = 1'b0;
            default: fire_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dacbank_chan.sv
`timescale 1ns/1ps
module dacbank_chan #(
    parameter int CODE_W = 18,
    parameter int SPAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_code_i,
    input  logic              wr_span_i,
    input  logic              upd_i,
    input  logic [CODE_W-1:0] code_d_i,
    input  logic [SPAN_W-1:0] span_d_i,
    output logic [CODE_W-1:0] in_code_o,
    output logic [SPAN_W-1:0] in_span_o,
    output logic [CODE_W-1:0] act_code_o,
    output logic [SPAN_W-1:0] act_span_o
);

    logic [CODE_W-1:0] in_code_d;
    logic [SPAN_W-1:0] in_span_d;

    // staged value as it stands after this cycle's write
    always_comb begin
        in_code_d = wr_code_i ? code_d_i : in_code_o;
        in_span_d = wr_span_i ? span_d_i : in_span_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_code_o  <= '0;
            in_span_o  <= '0;
            act_code_o <= '0;
            act_span_o <= '0;
        end else begin
            in_code_o <= in_code_d;
            in_span_o <= in_span_d;
            if (upd_i) begin
                act_code_o <= in_code_d;
                act_span_o <= in_span_d;
            end
        end
    end

endmodule

// File: rtl/dacbank_rbsel.sv
`timescale 1ns/1ps
module dacbank_rbsel
    import dacbank_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int CODE_W   = 18,
    parameter int SPAN_W   = 4,
    parameter int RB_W     = 24,
    parameter int SPAN_LSB = 8,
    parameter int CH_W     = 1
) (
    input  logic [NUM_CH*CODE_W-1:0] in_code_i,
    input  logic [NUM_CH*SPAN_W-1:0] in_span_i,
    input  logic [NUM_CH*CODE_W-1:0] act_code_i,
    input  logic [NUM_CH*SPAN_W-1:0] act_span_i,
    input  logic                     mspan_i,
    input  logic [SPAN_W-2:0]        pins_i,
    input  logic [CH_W-1:0]          sel_ch_i,
    input  regsel_e                  sel_reg_i,
    output logic [RB_W-1:0]          image_o
);

    logic [CODE_W-1:0] code_v;
    logic [SPAN_W-1:0] span_v;
    logic              is_span;

    always_comb begin
        code_v  = '0;
        span_v  = '0;
        is_span = 1'b0;
        unique case (sel_reg_i)
            RG_IN_CODE:  code_v = in_code_i[sel_ch_i*CODE_W +: CODE_W];
            RG_ACT_CODE: code_v = act_code_i[sel_ch_i*CODE_W +: CODE_W];
            RG_IN_SPAN: begin
                span_v  = in_span_i[sel_ch_i*SPAN_W +: SPAN_W];
                is_span = 1'b1;
            end
            RG_ACT_SPAN: begin
                span_v  = act_span_i[sel_ch_i*SPAN_W +: SPAN_W];
                is_span = 1'b1;
            end
            default: ;
        endcase
        if (mspan_i) begin
            span_v = {1'b0, pins_i};
        end
    end

    always_comb begin
        image_o = '0;
        if (is_span) begin
            image_o[SPAN_LSB +: SPAN_W] = span_v;
        end else begin
            image_o[RB_W-1 -: CODE_W] = code_v;
        end
    end

endmodule

// File: rtl/dacbank_regs.sv
`timescale 1ns/1ps
module dacbank_regs
    import dacbank_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int CODE_W      = 18,
    parameter int SPAN_W      = 4,
    parameter int RB_W        = 24,
    parameter int SPAN_LSB    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid_i,
    input  logic [2:0]               req_op_i,
    input  logic [CH_W-1:0]          req_ch_i,
    input  logic [1:0]               req_reg_i,
    input  logic [RB_W-1:0]          req_data_i,
    input  logic                     cs_n_i,
    input  logic                     ld_n_i,
    input  logic                     mspan_i,
    input  logic [SPAN_W-2:0]        span_pins_i,
    output logic [NUM_CH*CODE_W-1:0] act_code_o,
    output logic [NUM_CH*SPAN_W-1:0] act_span_o,
    output logic [RB_W-1:0]          rb_word_o
);

    localparam int CODE_LSB = RB_W - CODE_W;

    op_e                     op;
    logic                    frame_ok;
    logic                    is_wr;
    logic                    is_upd_one;
    logic                    is_upd_all;
    logic                    is_read;
    logic                    ld_fire;
    logic [CODE_W-1:0]       code_field;
    logic [SPAN_W-1:0]       span_field;
    logic [NUM_CH*CODE_W-1:0] in_code_all;
    logic [NUM_CH*SPAN_W-1:0] in_span_all;
    logic [NUM_CH*SPAN_W-1:0] act_span_raw;
    logic [CH_W-1:0]         ptr_ch_q;
    logic [CH_W-1:0]         ptr_ch_d;
    regsel_e                 ptr_reg_q;
    regsel_e                 ptr_reg_d;
    logic [CH_W-1:0]         sel_ch;
    regsel_e                 sel_reg;
    logic [RB_W-1:0]         image;

    // frame decode
    assign op         = op_e'(req_op_i);
    assign frame_ok   = req_valid_i && (req_op_i <= OP_LAST);
    assign is_wr      = frame_ok && (op == OP_WRITE || op == OP_WRITE_UPD);
    assign is_upd_one = frame_ok && (op == OP_UPDATE || op == OP_WRITE_UPD);
    assign is_upd_all = frame_ok && (op == OP_UPDATE_ALL);
    assign is_read    = frame_ok && (op == OP_READ);
    assign code_field = req_data_i[RB_W-1 -: CODE_W];
    assign span_field = req_data_i[SPAN_LSB +: SPAN_W];

    dacbank_ldsync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ldsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_n_i (ld_n_i),
        .cs_n_i (cs_n_i),
        .fire_o (ld_fire)
    );

    // per-channel register sets
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = (req_ch_i == CH_W'(g));

        dacbank_chan #(
            .CODE_W (CODE_W),
            .SPAN_W (SPAN_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_code_i  (is_wr && hit && !req_reg_i[0]),
            .wr_span_i  (is_wr && hit && req_reg_i[0]),
            .upd_i      ((is_upd_one && hit) || is_upd_all || ld_fire),
            .code_d_i   (code_field),
            .span_d_i   (span_field),
            .in_code_o  (in_code_all[g*CODE_W +: CODE_W]),
            .in_span_o  (in_span_all[g*SPAN_W +: SPAN_W]),
            .act_code_o (act_code_o[g*CODE_W +: CODE_W]),
            .act_span_o (act_span_raw[g*SPAN_W +: SPAN_W])
        );

        assign act_span_o[g*SPAN_W +: SPAN_W] =
            mspan_i ? {1'b0, span_pins_i} : act_span_raw[g*SPAN_W +: SPAN_W];
    end

    // rolling pointer: register acted on by the last write/update frame
    always_comb begin
        ptr_ch_d  = ptr_ch_q;
        ptr_reg_d = ptr_reg_q;
        if (frame_ok) begin
            unique case (op)
                OP_WRITE: begin
                    ptr_ch_d  = req_ch_i;
                    ptr_reg_d = req_reg_i[0] ? RG_IN_SPAN : RG_IN_CODE;
                end
                OP_UPDATE, OP_WRITE_UPD: begin
                    ptr_ch_d  = req_ch_i;
                    ptr_reg_d = RG_ACT_CODE;
                end
                OP_UPDATE_ALL: begin
                    ptr_ch_d  = '0;
                    ptr_reg_d = RG_ACT_CODE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_ch_q  <= '0;
            ptr_reg_q <= RG_IN_CODE;
        end else begin
            ptr_ch_q  <= ptr_ch_d;
            ptr_reg_q <= ptr_reg_d;
        end
    end

    // readback source: named register for reads, pointer otherwise
    assign sel_ch  = is_read ? req_ch_i : ptr_ch_q;
    assign sel_reg = is_read ? regsel_e'(req_reg_i) : ptr_reg_q;

    dacbank_rbsel #(
        .NUM_CH   (NUM_CH),
        .CODE_W   (CODE_W),
        .SPAN_W   (SPAN_W),
        .RB_W     (RB_W),
        .SPAN_LSB (SPAN_LSB),
        .CH_W     (CH_W)
    ) u_rbsel (
        .in_code_i  (in_code_all),
        .in_span_i  (in_span_all),
        .act_code_i (act_code_o),
        .act_span_i (act_span_raw),
        .mspan_i    (mspan_i),
        .pins_i     (span_pins_i),
        .sel_ch_i   (sel_ch),
        .sel_reg_i  (sel_reg),
        .image_o    (image)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_word_o <= '0;
        end else if (frame_ok) begin
            rb_word_o <= image;
        end
    end

    logic unused_low;
    assign unused_low = ^{req_data_i[CODE_LSB-1:0]};

endmodule

// File: rtl/dacbank_regs_chk.sv
`timescale 1ns/1ps
module dacbank_regs_chk #(
    parameter int NUM_CH   = 2,
    parameter int CODE_W   = 18,
    parameter int SPAN_W   = 4,
    parameter int RB_W     = 24,
    parameter int SPAN_LSB = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid_i,
    input logic [2:0]               req_op_i,
    input logic [1:0]               req_reg_i,
    input logic                     cs_n_i,
    input logic                     mspan_i,
    input logic [SPAN_W-2:0]        span_pins_i,
    input logic                     ld_fire,
    input logic [NUM_CH*CODE_W-1:0] act_code_o,
    input logic [NUM_CH*SPAN_W-1:0] act_span_o,
    input logic [RB_W-1:0]          rb_word_o
);

    p_rb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && req_op_i <= 3'd4) |=> $stable(rb_word_o));

    p_act_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_fire && !(req_valid_i && (req_op_i == 3'd1 || req_op_i == 3'd2 || req_op_i == 3'd3)))
        |=> $stable(act_code_o));

    p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fire |=> !ld_fire);

    p_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_i |-> !ld_fire);

    p_span_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 3'd4 && req_reg_i[0])
        |=> (rb_word_o[RB_W-1:SPAN_LSB+SPAN_W] == '0 && rb_word_o[SPAN_LSB-1:0] == '0));

    p_code_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_op_i == 3'd4 && !req_reg_i[0])
        |=> (rb_word_o[RB_W-CODE_W-1:0] == '0));

    p_manual_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mspan_i |-> (act_span_o == {NUM_CH{{1'b0, span_pins_i}}}));

endmodule

bind dacbank_regs dacbank_regs_chk #(
    .NUM_CH   (NUM_CH),
    .CODE_W   (CODE_W),
    .SPAN_W   (SPAN_W),
    .RB_W     (RB_W),
    .SPAN_LSB (SPAN_LSB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_reg_i   (req_reg_i),
    .cs_n_i      (cs_n_i),
    .mspan_i     (mspan_i),
    .span_pins_i (span_pins_i),
    .ld_fire     (ld_fire),
    .act_code_o  (act_code_o),
    .act_span_o  (act_span_o),
    .rb_word_o   (rb_word_o)
);

// File: tb/dacbank_regs_test.sv
`timescale 1ns/1ps
module dacbank_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [0:0]  req_ch = '0;
    logic [1:0]  req_reg = '0;
    logic [23:0] req_data = '0;
    logic        cs_n = 1'b1;
    logic        ld_n = 1'b1;
    logic        mspan = 1'b0;
    logic [2:0]  pins = '0;
    logic [35:0] act_code;
    logic [7:0]  act_span;
    logic [23:0] rb_word;

    int n_checks = 0;
    int n_errs   = 0;

    // reference model
    logic [17:0] m_in_code [2];
    logic [17:0] m_act_code [2];
    logic [3:0]  m_in_span [2];
    logic [3:0]  m_act_span [2];
    int          m_ptr_ch;
    logic [1:0]  m_ptr_reg;
    logic [23:0] m_rb;

    // {op[2:0], ch, reg[1:0], data[23:0]}
    localparam logic [29:0] VECS [16] = '{
        {3'd0, 1'b0, 2'd0, 24'hABCDFF},
        {3'd0, 1'b1, 2'd1, 24'hFF05FF},
        {3'd0, 1'b1, 2'd0, 24'h12347F},
        {3'd1, 1'b0, 2'd0, 24'h000000},
        {3'd4, 1'b0, 2'd2, 24'h000000},
        {3'd4, 1'b1, 2'd1, 24'hFFFFFF},
        {3'd2, 1'b1, 2'd0, 24'hFFFFC0},
        {3'd0, 1'b0, 2'd1, 24'h000300},
        {3'd3, 1'b1, 2'd3, 24'h000000},
        {3'd4, 1'b0, 2'd3, 24'h000000},
        {3'd0, 1'b0, 2'd2, 24'h000040},
        {3'd4, 1'b1, 2'd2, 24'h000000},
        {3'd1, 1'b1, 2'd1, 24'h000000},
        {3'd0, 1'b1, 2'd0, 24'h800000},
        {3'd7, 1'b0, 2'd0, 24'hFFFFFF},
        {3'd0, 1'b0, 2'd1, 24'h000F00}
    };

    dacbank_regs uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_op_i    (req_op),
        .req_ch_i    (req_ch),
        .req_reg_i   (req_reg),
        .req_data_i  (req_data),
        .cs_n_i      (cs_n),
        .ld_n_i      (ld_n),
        .mspan_i     (mspan),
        .span_pins_i (pins),
        .act_code_o  (act_code),
        .act_span_o  (act_span),
        .rb_word_o   (rb_word)
    );

    always #4 clk = ~clk;

    function automatic logic [23:0] img(int ch, logic [1:0] rg);
        logic [23:0] r = '0;
        logic [3:0]  sp;
        case (rg)
            2'd0: r[23:6] = m_in_code[ch];
            2'd2: r[23:6] = m_act_code[ch];
            default: begin
                sp = (rg == 2'd1) ? m_in_span[ch] : m_act_span[ch];
                if (mspan) sp = {1'b0, pins};
                r[11:8] = sp;
            end
        endcase
        return r;
    endfunction

    task automatic check(string req, string what, logic [35:0] act, logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(string rb_req, string act_req);
        check(rb_req, "readback", 36'(rb_word), 36'(m_rb));
        for (int c = 0; c < 2; c++) begin
            check(act_req, "active code", 36'(act_code[c*18 +: 18]), 36'(m_act_code[c]));
            check(act_req, "active span", 36'(act_span[c*4 +: 4]),
                  36'(mspan ? {1'b0, pins} : m_act_span[c]));
        end
    endtask

    task automatic m_upd_all();
        for (int c = 0; c < 2; c++) begin
            m_act_code[c] = m_in_code[c];
            m_act_span[c] = m_in_span[c];
        end
    endtask

    task automatic m_apply(logic [2:0] op, int ch, logic [1:0] rg, logic [23:0] data, bit with_ld);
        if (op <= 3'd4) begin
            m_rb = (op == 3'd4) ? img(ch, rg) : img(m_ptr_ch, m_ptr_reg);
            if (op == 3'd0 || op == 3'd2) begin
                if (rg[0]) m_in_span[ch] = data[11:8];
                else       m_in_code[ch] = data[23:6];
            end
            if (op == 3'd1 || op == 3'd2) begin
                m_act_code[ch] = m_in_code[ch];
                m_act_span[ch] = m_in_span[ch];
            end
            if (op == 3'd3) m_upd_all();
            case (op)
                3'd0: begin m_ptr_ch = ch; m_ptr_reg = {1'b0, rg[0]}; end
                3'd1, 3'd2: begin m_ptr_ch = ch; m_ptr_reg = 2'd2; end
                3'd3: begin m_ptr_ch = 0; m_ptr_reg = 2'd2; end
                default: ;
            endcase
        end
        if (with_ld) m_upd_all();
    endtask

    task automatic drive_frame(logic [2:0] op, int ch, logic [1:0] rg, logic [23:0] data);
        @(negedge clk);
        req_op = op; req_ch = 1'(ch); req_reg = rg; req_data = data;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic frame(logic [2:0] op, int ch, logic [1:0] rg, logic [23:0] data, string act_req);
        string rb_req;
        rb_req = (op == 3'd4) ? "R5" : (op <= 3'd3) ? "R6" : "R10";
        m_apply(op, ch, rg, data, 1'b0);
        drive_frame(op, ch, rg, data);
        check_outs(rb_req, act_req);
    endtask

    initial begin
        #1600000;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_in_code[c] = '0; m_act_code[c] = '0;
            m_in_span[c] = '0; m_act_span[c] = '0;
        end
        m_ptr_ch = 0; m_ptr_reg = 2'd0; m_rb = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R1", "R1");

        // vector table walk
        for (int i = 0; i < 16; i++) begin
            logic [29:0] v;
            string areq;
            v = VECS[i];
            case (v[29:27])
                3'd0: areq = "R2";
                3'd1, 3'd2: areq = "R3";
                3'd3: areq = "R4";
                3'd4: areq = "R5";
                default: areq = "R10";
            endcase
            frame(v[29:27], int'(v[26]), v[25:24], v[23:0], areq);
        end

        // R10: invalid ops leave pointer and readback alone
        frame(3'd5, 1, 2'd2, 24'hFFFFFF, "R10");
        frame(3'd6, 0, 2'd0, 24'h123456, "R10");
        frame(3'd1, 0, 2'd0, 24'h0, "R6");

        // R7: load pin with chip select high
        frame(3'd0, 0, 2'd0, 24'h5555C0, "R2");
        frame(3'd0, 1, 2'd1, 24'h000A00, "R2");
        @(negedge clk); ld_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_outs("R7", "R7");
        @(negedge clk);
        m_upd_all();
        check_outs("R7", "R7");
        frame(3'd0, 0, 2'd0, 24'h0000C0, "R7");
        repeat (4) @(negedge clk);
        check_outs("R7", "R7");
        ld_n = 1'b1;
        repeat (4) @(negedge clk);
        check_outs("R7", "R7");

        // R8: lockout while chip select low
        cs_n = 1'b0;
        ld_n = 1'b0;
        repeat (5) @(negedge clk);
        check_outs("R8", "R8");
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check_outs("R8", "R8");
        ld_n = 1'b1;
        repeat (4) @(negedge clk);
        check_outs("R8", "R8");

        // R9: manual span
        frame(3'd0, 1, 2'd1, 24'h000600, "R9");
        mspan = 1'b1; pins = 3'b101;
        @(negedge clk);
        check_outs("R9", "R9");
        frame(3'd4, 0, 2'd1, 24'h0, "R9");
        frame(3'd4, 1, 2'd3, 24'h0, "R9");
        frame(3'd0, 0, 2'd1, 24'h000900, "R9");
        frame(3'd1, 0, 2'd0, 24'h0, "R9");
        frame(3'd0, 1, 2'd0, 24'h000000, "R9");
        pins = 3'b010;
        @(negedge clk);
        check_outs("R9", "R9");
        mspan = 1'b0;
        @(negedge clk);
        check_outs("R9", "R9");
        frame(3'd4, 1, 2'd1, 24'h0, "R9");
        frame(3'd4, 0, 2'd3, 24'h0, "R9");

        // R11: load event and write frame on the same edge
        frame(3'd0, 0, 2'd0, 24'hC0FFC0, "R2");
        m_apply(3'd0, 1, 2'd0, 24'h3AB000, 1'b1);
        @(negedge clk); ld_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        req_op = 3'd0; req_ch = 1'b1; req_reg = 2'd0; req_data = 24'h3AB000;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_outs("R11", "R11");
        ld_n = 1'b1;
        repeat (4) @(negedge clk);
        frame(3'd0, 0, 2'd1, 24'h000100, "R11");

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int c = 0; c < 2; c++) begin
            m_in_code[c] = '0; m_act_code[c] = '0;
            m_in_span[c] = '0; m_act_span[c] = '0;
        end
        m_ptr_ch = 0; m_ptr_reg = 2'd0; m_rb = '0;
        @(negedge clk);
        check_outs("R1", "R1");
        frame(3'd0, 1, 2'd1, 24'h000700, "R1");

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule